// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers a set of interrupt sources and raises one interrupt request toward a processor. Some sources are hardware inputs and some are flags that software sets and clears through registers. Each source carries a programmable priority level. The request goes out only while some asserted source ranks strictly above the current priority level held in the controller.

A claim moves the current priority up to the level of the source being served, so only strictly higher sources can preempt that handler. A claim also pushes the old level onto a small hardware stack. A claim is made in one of two ways:
- In software-vector mode, the processor reads an acknowledge register, which returns the vector and makes the claim.
- In hardware-vector mode, the vector is driven beside the request and an acknowledge strobe makes the claim.

An end-of-interrupt write pops the stack back into the current priority. The controller does not look for the interrupted source again. That source resumes simply because the processor returns to it, and it cannot raise a fresh request unless it now ranks above the restored level.

Registers sit behind a plain read/write port. Read data is returned on the clock edge that samples the read strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq_o` is high one edge after an asserted source has a priority strictly greater than the current priority level (CPR, address 0x01, bits [3:0]), and is low when no source meets this. It comes out of reset low, with CPR and CFG both reading 0.
- R2: The vector on `vec_o` is the index of the source that wins. The winner is the source with the highest priority, and ties go to the lowest index. Sources 0..7 are the software flags and source 8+j is `hw_req[j]`. The priority of source s sits at address 0x20+s, bits [3:0]. `vec_o` is 0 when no source qualifies.
- R3: In software-vector mode (CFG address 0x00, bit0 = 0), a read of the acknowledge register (address 0x02) while `irq_o` is high returns the vector in bits [4:0]. The same read loads CPR with the winner's priority and pushes the previous CPR onto the stack.
- R4: In hardware-vector mode (CFG bit0 = 1), a `cpu_ack` pulse while `irq_o` is high makes the claim. In this mode an acknowledge-register read returns the vector but changes neither CPR nor `irq_o`.
- R5: `irq_o` is low in the cycle after a claim. It rises again only for a source whose priority is above the new CPR.
- R6: Any write to address 0x03 pops the stack into CPR. A source still asserted at or below the restored level does not raise `irq_o`, while a source above it does.
- R7: A pop from an empty stack loads CPR with 0.
- R8: The stack holds 15 levels. A 16th push is discarded and sets a sticky overflow bit, CFG bit1, which only reset clears.
- R9: A software write to CPR changes only CPR. A later pop returns the level that the last claim pushed.
- R10: A source with priority 0 never raises `irq_o`.
- R11: Writing 1s to address 0x04 sets software flags and writing 1s to address 0x05 clears them. Reading address 0x04 returns the flags.
- R12: When a claim and an end-of-interrupt write fall in the same cycle, the claim takes effect and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 24 | Hardware interrupt requests, sources 8..31 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid after the edge that samples the read |
| cpu_ack | input | 1 | Processor acknowledge strobe (hardware-vector mode) |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 5 | Vector of the winning source |

## Verification
`irq_o` and `vec_o` follow a change in the requests one edge later. After a claim, an end-of-interrupt write or a CPR write, `irq_o` is held low for one cycle and reflects the new level on the edge after that. `reg_rdata` holds the result from the edge that sampled the read. The bench drives every input on the falling edge and samples one falling edge after the relevant rising edge. Before each claim or check that depends on a level change, it waits the extra cycle of masking so that every sample lands where its result is due.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CFG       = 6'h00;
  localparam logic [ADDR_W-1:0] A_CPR       = 6'h01;
  localparam logic [ADDR_W-1:0] A_IACK      = 6'h02;
  localparam logic [ADDR_W-1:0] A_EOI       = 6'h03;
  localparam logic [ADDR_W-1:0] A_SWSET     = 6'h04;
  localparam logic [ADDR_W-1:0] A_SWCLR     = 6'h05;
  localparam logic [ADDR_W-1:0] A_PRIO_BASE = 6'h20;
endpackage

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int N_SRC = 32,
  parameter int PRI_W = 4,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req,
  input  logic [PRI_W-1:0] prio [N_SRC],
  input  logic [PRI_W-1:0] level,
  output logic             win_valid,
  output logic [VEC_W-1:0] win_idx,
  output logic [PRI_W-1:0] win_pri
);
  // Scan from the top index down so that ">=" leaves the lowest index on ties.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_pri   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i] && (prio[i] > level) && (prio[i] >= win_pri)) begin
        win_valid = 1'b1;
        win_idx   = VEC_W'(i);
        win_pri   = prio[i];
      end
    end
  end
endmodule

// File: rtl/prio_lifo.sv
module prio_lifo #(
  parameter int DEPTH = 15,
  parameter int W     = 4,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] sp;
  logic             full, empty;

  assign full  = (sp == PTR_W'(DEPTH));
  assign empty = (sp == '0);
  assign dout  = empty ? '0 : mem[sp - 1'b1];

  // Storage without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push && !full) mem[sp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      ovf <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      sp  <= sp + 1'b1;
    end else if (pop && !empty) begin
      sp <= sp - 1'b1;
    end
  end

  a_r8_full_push_flags: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r3_push_grows: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (sp == $past(sp) + 1'b1));
  a_r7_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> (sp == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC      = 32,
  parameter int N_SW       = 8,
  parameter int PRI_W      = 4,
  parameter int LIFO_DEPTH = 15,
  parameter int DATA_W     = 32,
  localparam int VEC_W     = $clog2(N_SRC),
  localparam int N_HW      = N_SRC - N_SW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_HW-1:0]   hw_req,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_ack,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic              hw_mode_q;
  logic [PRI_W-1:0]  pri_q;
  logic [N_SW-1:0]   sw_flags_q;
  logic [PRI_W-1:0]  prio_q [N_SRC];
  logic              irq_q;
  logic [VEC_W-1:0]  vec_q;
  logic [PRI_W-1:0]  wpri_q;
  logic [DATA_W-1:0] rdata_q;

  logic [N_SRC-1:0]  req_all;
  logic              win_valid;
  logic [VEC_W-1:0]  win_idx;
  logic [PRI_W-1:0]  win_pri;
  logic [PRI_W-1:0]  pop_val;
  logic              ovf;
  logic              wr_cfg, wr_cpr, wr_eoi, wr_set, wr_clr, rd_iack;
  logic              claim, eoi;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:N_SW];

  assign req_all = {hw_req, sw_flags_q};

  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
  assign wr_cpr  = reg_wr && (reg_addr == A_CPR);
  assign wr_eoi  = reg_wr && (reg_addr == A_EOI);
  assign wr_set  = reg_wr && (reg_addr == A_SWSET);
  assign wr_clr  = reg_wr && (reg_addr == A_SWCLR);
  assign rd_iack = reg_rd && (reg_addr == A_IACK);

  // A claim always serves the request the processor currently sees.
  assign claim = irq_q && (hw_mode_q ? cpu_ack : rd_iack);
  assign eoi   = wr_eoi && !claim;

  prio_arbiter #(.N_SRC(N_SRC), .PRI_W(PRI_W)) arb_i (
    .req(req_all), .prio(prio_q), .level(pri_q),
    .win_valid(win_valid), .win_idx(win_idx), .win_pri(win_pri)
  );

  prio_lifo #(.DEPTH(LIFO_DEPTH), .W(PRI_W)) lifo_i (
    .clk(clk), .rst(rst), .push(claim), .pop(eoi),
    .din(pri_q), .dout(pop_val), .ovf(ovf)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst)
        prio_q[g] <= '0;
      else if (reg_wr && (reg_addr == (A_PRIO_BASE | ADDR_W'(g))))
        prio_q[g] <= reg_wdata[PRI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_mode_q  <= 1'b0;
      pri_q      <= '0;
      sw_flags_q <= '0;
    end else begin
      if (wr_cfg) hw_mode_q <= reg_wdata[0];
      if (claim)       pri_q <= wpri_q;
      else if (eoi)    pri_q <= pop_val;
      else if (wr_cpr) pri_q <= reg_wdata[PRI_W-1:0];
      if (wr_set)      sw_flags_q <= sw_flags_q | reg_wdata[N_SW-1:0];
      else if (wr_clr) sw_flags_q <= sw_flags_q & ~reg_wdata[N_SW-1:0];
    end
  end

  // Request masked for one cycle whenever the level is about to change.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      wpri_q <= '0;
    end else begin
      irq_q  <= win_valid && !(claim || eoi || wr_cpr);
      vec_q  <= win_valid ? win_idx : '0;
      wpri_q <= win_pri;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr[ADDR_W-1]) begin
      rd_mux[PRI_W-1:0] = prio_q[reg_addr[VEC_W-1:0]];
    end else begin
      case (reg_addr)
        A_CFG:   rd_mux[1:0]       = {ovf, hw_mode_q};
        A_CPR:   rd_mux[PRI_W-1:0] = pri_q;
        A_IACK:  rd_mux[VEC_W-1:0] = vec_q;
        A_SWSET: rd_mux[N_SW-1:0]  = sw_flags_q;
        default: rd_mux            = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign vec_o     = vec_q;

  a_r1_irq_above_level: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (wpri_q > pri_q));
  a_r10_zero_never_wins: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (prio_q[vec_q] != '0));
  a_r3_claim_loads_level: assert property (@(posedge clk) disable iff (rst)
    claim |=> (pri_q == $past(wpri_q)));
  a_r5_drop_after_claim: assert property (@(posedge clk) disable iff (rst)
    claim |=> !irq_q);
  a_r6_eoi_restores: assert property (@(posedge clk) disable iff (rst)
    eoi |=> (pri_q == $past(pop_val)));
  a_r12_claim_beats_eoi: assert property (@(posedge clk) disable iff (rst)
    (claim && wr_eoi) |=> (pri_q == $past(wpri_q)));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] hw_req = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_ack = 1'b0;
  logic        irq_o;
  logic [4:0]  vec_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .hw_req(hw_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_ack(cpu_ack), .irq_o(irq_o), .vec_o(vec_o)
  );

  // {hw_req, expected irq, expected vector}; level 2, priorities from set_prios
  localparam logic [29:0] TBL [8] = '{
    {24'h000000, 1'b0, 5'd0},
    {24'h000001, 1'b1, 5'd8},
    {24'h000006, 1'b1, 5'd9},
    {24'h000011, 1'b1, 5'd12},
    {24'h800000, 1'b0, 5'd0},
    {24'h001010, 1'b1, 5'd20},
    {24'h000008, 1'b0, 5'd0},
    {24'h800002, 1'b1, 5'd9}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ack_pulse(input bit with_eoi);
    cpu_ack = 1'b1;
    if (with_eoi) begin reg_wr = 1'b1; reg_addr = 6'h03; reg_wdata = '0; end
    @(posedge clk);
    @(negedge clk);
    cpu_ack = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; hw_req = '0;
    wait_clk(3);
    rst = 1'b0;
  endtask

  task automatic set_prios();
    wr(6'h28, 3);  wr(6'h29, 5);  wr(6'h2A, 5);  wr(6'h2C, 9);
    wr(6'h34, 15); wr(6'h3F, 1);  wr(6'h22, 7);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 reset irq", irq_o, 0);
    rd(6'h01, d); check("R1 reset CPR", d, 0);
    rd(6'h00, d); check("R1 reset CFG", d, 0);

    set_prios();
    wr(6'h01, 2);
    wait_clk(1);
    // R1 R2 R10 table
    for (int i = 0; i < 8; i++) begin
      hw_req = TBL[i][29:6];
      wait_clk(1);
      check($sformatf("R1 irq entry %0d", i), irq_o, TBL[i][5]);
      check($sformatf("R2 vec entry %0d", i), vec_o, TBL[i][4:0]);
    end

    // R3 R5 R6 R7: nested claims in software-vector mode
    hw_req = 24'h000010;              // source 12, priority 9
    wait_clk(2);
    rd(6'h02, d); check("R3 iack vector", d, 12);
    check("R5 irq low after claim", irq_o, 0);
    rd(6'h01, d); check("R3 CPR raised", d, 9);
    hw_req = 24'h001010;              // add source 20, priority 15
    wait_clk(1);
    check("R5 preempt irq", irq_o, 1);
    check("R5 preempt vec", vec_o, 20);
    rd(6'h02, d); check("R3 nested vector", d, 20);
    rd(6'h01, d); check("R3 nested CPR", d, 15);
    hw_req = 24'h000010;
    wr(6'h03, 0);
    wait_clk(2);
    rd(6'h01, d); check("R6 pop to 9", d, 9);
    check("R6 no re-raise at level", irq_o, 0);
    wr(6'h03, 0);
    wait_clk(2);
    rd(6'h01, d); check("R6 pop to 2", d, 2);
    check("R6 above restored level", irq_o, 1);
    wr(6'h03, 0);
    wr(6'h03, 0);
    rd(6'h01, d); check("R7 empty pop gives 0", d, 0);

    // R10 priority-0 source at level 0
    hw_req = 24'h000008;
    wait_clk(2);
    check("R10 zero priority masked", irq_o, 0);

    // R9 level write leaves the stack alone
    hw_req = 24'h000010;
    wr(6'h01, 2);
    wait_clk(1);
    rd(6'h02, d);
    wr(6'h01, 4);
    wr(6'h03, 0);
    rd(6'h01, d); check("R9 pop after level write", d, 2);
    wr(6'h03, 0);

    // R8 overflow
    hw_req = 24'h001000;              // source 20, priority 15
    for (int k = 0; k < 15; k++) begin
      wr(6'h01, k);
      wait_clk(1);
      rd(6'h02, d);
    end
    rd(6'h00, d); check("R8 full no overflow", d, 0);
    wr(6'h01, 14);
    wait_clk(1);
    rd(6'h02, d);
    rd(6'h00, d); check("R8 overflow sticky bit", d, 2);
    wr(6'h03, 0);
    rd(6'h01, d); check("R8 top after drop", d, 14);
    wr(6'h03, 0);
    rd(6'h01, d); check("R8 second pop", d, 13);
    rd(6'h00, d); check("R8 overflow stays", d, 2);

    // R11 software flags
    do_reset();
    set_prios();
    wr(6'h04, 32'h4);
    wait_clk(1);
    check("R11 soft irq", irq_o, 1);
    check("R11 soft vec", vec_o, 2);
    rd(6'h04, d); check("R11 flags read", d, 4);
    wr(6'h05, 32'h4);
    wait_clk(2);
    check("R11 cleared", irq_o, 0);

    // R4 R12 hardware-vector mode
    wr(6'h00, 1);
    hw_req = 24'h000010;
    wait_clk(2);
    check("R4 irq with vector", irq_o, 1);
    check("R4 vector out", vec_o, 12);
    rd(6'h02, d); check("R4 iack read vector", d, 12);
    rd(6'h01, d); check("R4 read does not claim", d, 0);
    check("R4 irq kept", irq_o, 1);
    ack_pulse(1'b0);
    check("R5 hw irq dropped", irq_o, 0);
    rd(6'h01, d); check("R4 ack claims", d, 9);
    hw_req = 24'h001010;
    wait_clk(2);
    check("R4 preempt vec", vec_o, 20);
    ack_pulse(1'b1);
    rd(6'h01, d); check("R12 claim beats eoi", d, 15);
    wr(6'h03, 0);
    rd(6'h01, d); check("R12 stack intact", d, 9);

    done = 1'b1;
    report();
  end
endmodule